// File: doc/BRIEF.md
# Masked Write Lane Splitter Memory

This block is a single-port read/write memory whose writes can be restricted to chosen segments of the word. It has no masked storage. The word is cut into equal lanes, and each lane lives in its own unmasked single-port bank. All banks have the full logical depth. The banks share clock, address and enable. Each bank takes its own lane of the write data and returns the same lane of the read data.

A bank enters write mode only when the global write mode is set and that bank's mask bit is set. The mask therefore becomes a per-bank gate on write mode. A bank whose mask bit is clear performs an ordinary read during a write cycle. The read data returned in a write cycle carries no defined meaning for those lanes.

Reads are synchronous. The word addressed in a read cycle appears on the read-data output after the next rising clock edge. It then holds until the next read.

Top module: `lane_split_mem`

## Requirements
- R1: After the active-low reset is released, `rdata_o` is all zeros until the first read completes.
- R2: A read (`en_i`=1, `wmode_i`=0) returns the stored word of `addr_i` on `rdata_o` after the next rising edge. With all mask bits set, a write stores the whole `wdata_i` word.
- R3: In a write cycle, mask bit i (bit i of `wmask_i`) enables only lane i, which is data bits [GRAN*(i+1)-1 : GRAN*i]. Lanes whose mask bit is clear keep their stored contents.
- R4: A write with `wmask_i` all zeros leaves the addressed word unchanged.
- R5: With `en_i`=0, no location is written, whatever `wmode_i` and `wmask_i` are, and `rdata_o` holds its value.
- R6: `rdata_o` keeps the last word read while no read is performed.
- R7: Every address is independent storage. Writing one location does not alter another, including the first and last addresses.
- R8: In a write cycle, the lanes being written keep their previous `rdata_o` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by all banks |
| rst_ni | input | 1 | Asynchronous active-low reset of the read-data registers |
| en_i | input | 1 | Access enable shared by all banks |
| wmode_i | input | 1 | Global write mode; 0 selects a read |
| addr_i | input | AW | Word address shared by all banks |
| wmask_i | input | WIDTH/GRAN | One write-enable bit per lane |
| wdata_i | input | WIDTH | Write word, lane i in bits [GRAN*(i+1)-1 : GRAN*i] |
| rdata_o | output | WIDTH | Registered read word |

## Verification
The assertions assume that the address is a known value whenever the enable is high. They also assume that the read data of an unmasked lane in a write cycle is never consumed. The stimulus changes inputs only on the falling edge and drives the address to a defined value on every enabled cycle. It compares the read data of unmasked lanes during writes against nothing. The bench keeps its own copy of the memory contents and updates it lane by lane from the mask.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;
  function automatic int addr_bits(input int depth);
    int b;
    b = 1;
    while ((1 << b) < depth) b++;
    return b;
  endfunction
endpackage

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (en_i && !we_i)   rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o));

  p_write_keeps_rdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> $stable(rdata_o));
endmodule

// File: rtl/lane_we_gate.sv
module lane_we_gate #(
  parameter int NB = 4
) (
  input  logic          wmode_i,
  input  logic [NB-1:0] wmask_i,
  output logic [NB-1:0] we_o
);
  for (genvar i = 0; i < NB; i++) begin : g_gate
    assign we_o[i] = wmode_i & wmask_i[i];
  end
endmodule

// File: rtl/lane_split_mem.sv
module lane_split_mem
  import lane_split_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GRAN  = 8,
  parameter int DEPTH = 64,
  localparam int NB   = WIDTH / GRAN,
  localparam int AW   = addr_bits(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wmode_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB-1:0]    wmask_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  if (WIDTH % GRAN != 0) begin : g_bad_gran
    $error("WIDTH must be a multiple of GRAN");
  end

  logic [NB-1:0] bank_we;

  lane_we_gate #(.NB(NB)) u_gate (
    .wmode_i (wmode_i),
    .wmask_i (wmask_i),
    .we_o    (bank_we)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    lane_bank #(.DW(GRAN), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .we_i    (bank_we[i]),
      .addr_i  (addr_i),
      .wdata_i (wdata_i[GRAN*i +: GRAN]),
      .rdata_o (rdata_o[GRAN*i +: GRAN])
    );
  end

  p_we_needs_wmode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we != '0) |-> (wmode_i && ((bank_we & ~wmask_i) == '0)));

  p_addr_known_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> !$isunknown(addr_i));
endmodule

// File: tb/lane_split_mem_tb.sv
module lane_split_mem_tb;
  localparam int WIDTH = 32, GRAN = 8, DEPTH = 64, NB = WIDTH / GRAN, AW = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0, wmode_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [NB-1:0]    wmask_i = '0;
  logic [WIDTH-1:0] wdata_i = '0;
  logic [WIDTH-1:0] rdata_o;

  logic [WIDTH-1:0] model [DEPTH];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_split_mem #(.WIDTH(WIDTH), .GRAN(GRAN), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .wmode_i(wmode_i),
    .addr_i(addr_i), .wmask_i(wmask_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [NB-1:0] m, input logic [WIDTH-1:0] d);
    @(negedge clk);
    en_i = 1'b1; wmode_i = 1'b1; addr_i = AW'(a); wmask_i = m; wdata_i = d;
    @(negedge clk);
    en_i = 1'b0; wmode_i = 1'b0; wmask_i = '0;
    for (int i = 0; i < NB; i++)
      if (m[i]) model[a][GRAN*i +: GRAN] = d[GRAN*i +: GRAN];
  endtask

  task automatic do_read(input int a, output logic [WIDTH-1:0] q);
    @(negedge clk);
    en_i = 1'b1; wmode_i = 1'b0; addr_i = AW'(a);
    @(negedge clk);
    en_i = 1'b0;
    q = rdata_o;
  endtask

  task automatic t_reset;
    check("R1", rdata_o, '0);
  endtask

  task automatic t_full_words;
    logic [WIDTH-1:0] q;
    do_write(0, '1, 32'hA1B2C3D4);
    do_write(5, '1, 32'h01234567);
    do_write(DEPTH-1, '1, 32'hDEADBEEF);
    do_read(5, q);       check("R2", q, 32'h01234567);
    do_read(0, q);       check("R7", q, model[0]);
    do_read(DEPTH-1, q); check("R7", q, model[DEPTH-1]);
  endtask

  task automatic t_masked;
    logic [WIDTH-1:0] q;
    do_write(5, 4'b0101, 32'hFFFFFFFF);
    do_read(5, q); check("R3", q, 32'h01FF45FF);
    do_write(5, 4'b1000, 32'h77000000);
    do_read(5, q); check("R3", q, 32'h77FF45FF);
    do_write(0, 4'b0010, 32'h0000EE00);
    do_read(0, q); check("R3", q, 32'hA1B2EED4);
    do_read(5, q); check("R7", q, model[5]);
  endtask

  task automatic t_zero_mask;
    logic [WIDTH-1:0] q;
    do_write(DEPTH-1, 4'b0000, 32'h12345678);
    do_read(DEPTH-1, q); check("R4", q, 32'hDEADBEEF);
  endtask

  task automatic t_disabled;
    logic [WIDTH-1:0] q, held;
    do_read(0, held);
    @(negedge clk);
    en_i = 1'b0; wmode_i = 1'b1; addr_i = AW'(5); wmask_i = '1; wdata_i = 32'h55555555;
    @(negedge clk);
    check("R5", rdata_o, held);
    wmode_i = 1'b0; wmask_i = '0;
    do_read(5, q); check("R5", q, model[5]);
  endtask

  task automatic t_hold;
    logic [WIDTH-1:0] q;
    do_read(DEPTH-1, q);
    repeat (3) @(negedge clk);
    check("R6", rdata_o, model[DEPTH-1]);
  endtask

  task automatic t_write_lane_stable;
    logic [WIDTH-1:0] q;
    do_read(0, q);
    do_write(DEPTH-1, 4'b1001, 32'h99000066);
    check("R8", rdata_o & 32'hFF0000FF, q & 32'hFF0000FF);
    do_read(DEPTH-1, q); check("R3", q, model[DEPTH-1]);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_words();
    t_masked();
    t_zero_mask();
    t_disabled();
    t_hold();
    t_write_lane_stable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule